// File: doc/BRIEF.md
# Timer Pin GPIO and Edge Capture Unit

This block owns the single I/O pin of one general-purpose timer channel. Software picks what the pin does through a handful of mode fields. It can be a plain GPIO input, a GPIO output held low or high, either push-pull or open-drain, or an interrupt input that raises a sticky event on a chosen signal edge. The counter, the prescaler and any watchdog use of the channel belong elsewhere. This unit sees only their mode settings and the pin.

The pin input first passes through a synchronizer. Its settled level is shown in the status word, and edge detection works on that same settled value. Edge events are kept in four status flags. Software clears them by writing ones to a status write port. The interrupt line is the OR of the flags, gated by an enable. When the function field selects input capture, any output request is ignored and the pin stays an input.

Top module: `pin_io_top`

## Requirements
- R1: The status level bit (statusWord bit 8) shows pinIn after two clock edges of synchronization, and does so whatever the function field selects.
- R2: When not in capture mode, the two-bit output field selects the direction. Codes 00 and 01 release the pin (pinOe=0). Code 10 drives it low (pinOe=1, pinOut=0). Code 11 drives it high (pinOe=1, pinOut=1).
- R3: With modeOpenDrain=1, output code 11 releases the pin (pinOe=0) and code 10 still drives it low.
- R4: Edge events are generated only while the function field modeFunc equals 1 (input capture). Under any other function value, edges leave the flags unchanged.
- R5: The edge select field modeEdge chooses what triggers an event: 01 rising, 10 falling, 11 either edge, 00 no edge.
- R6: A detected edge sets flag bit 0 (event). Rising edges also set bit 1 and falling edges also set bit 2. Bit 3 (overrun) is set when an edge arrives while bit 0 is already set and bit 0 is not being cleared in that cycle. Flags appear in statusWord bits 3:0 on the third clock edge after the pin change.
- R7: A status write with statusWrEn=1 clears exactly the flag bits written as one. Bits written as zero keep their value.
- R8: When an edge sets a flag in the same cycle a write clears it, the flag ends up set.
- R9: irqOut is high exactly while modeIrqEn=1 and at least one flag is set.
- R10: In capture mode (modeFunc=1) the pin is never driven, whatever the output field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| modeFunc | input | 3 | Pin function select, 1 = input capture |
| modeGpio | input | 2 | Output field: 0x input, 10 low, 11 high |
| modeOpenDrain | input | 1 | Open-drain output style |
| modeIrqEn | input | 1 | Interrupt enable |
| modeEdge | input | 2 | Capture edge select |
| statusWrEn | input | 1 | Status write strobe |
| statusWrData | input | 4 | Write-one-to-clear mask for the flags |
| pinIn | input | 1 | Pin level from the pad |
| pinOut | output | 1 | Value driven on the pad |
| pinOe | output | 1 | Pad output enable |
| statusWord | output | 16 | Bit 8 pin level, bits 3:0 event flags |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an edge and a clear write landing on the same clock edge. The edge strobe only exists for one cycle, two synchronizer stages after the pin moves. The stimulus therefore changes the pin on a falling clock edge, waits out exactly two rising edges, and then raises the clear strobe for the one cycle in which the edge is being registered. The overrun flag is reached by producing a second edge without clearing in between, using the both-edges setting.

// File: rtl/pin_io_pkg.sv
package pin_io_pkg;
  localparam int EVT_W = 4;
  localparam int EVT_ANY = 0;
  localparam int EVT_RISE = 1;
  localparam int EVT_FALL = 2;
  localparam int EVT_OVR = 3;
  localparam int LEVEL_BIT = 8;
  localparam logic [2:0] FUNC_CAPTURE = 3'd1;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeSel_e;

  typedef struct packed {
    logic             armRise;
    logic             armFall;
    logic             driveEn;
    logic             driveHigh;
    logic             openDrain;
    logic             irqEnable;
    logic [EVT_W-1:0] clearMask;
  } pinCtl_t;
endpackage

// File: rtl/pin_io_sync.sv
module pin_io_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  genvar g;
  generate
    for (g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign dout = chain[LAST];
endmodule

// File: rtl/pin_io_ctrl.sv
module pin_io_ctrl
  import pin_io_pkg::*;
(
  input  logic [2:0]       modeFunc,
  input  logic [1:0]       modeGpio,
  input  logic             modeOpenDrain,
  input  logic             modeIrqEn,
  input  logic [1:0]       modeEdge,
  input  logic             statusWrEn,
  input  logic [EVT_W-1:0] statusWrData,
  output pinCtl_t          ctl
);
  logic     captureOn;
  edgeSel_e edgeSel;

  always_comb begin
    captureOn     = (modeFunc == FUNC_CAPTURE);
    edgeSel       = edgeSel_e'(modeEdge);
    ctl.armRise   = captureOn && (edgeSel == EDGE_RISE || edgeSel == EDGE_BOTH);
    ctl.armFall   = captureOn && (edgeSel == EDGE_FALL || edgeSel == EDGE_BOTH);
    ctl.driveEn   = !captureOn && modeGpio[1];
    ctl.driveHigh = modeGpio[0];
    ctl.openDrain = modeOpenDrain;
    ctl.irqEnable = modeIrqEn;
    ctl.clearMask = statusWrEn ? statusWrData : '0;
  end
endmodule

// File: rtl/pin_io_dp.sv
module pin_io_dp
  import pin_io_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STAT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pinIn,
  input  pinCtl_t           ctl,
  output logic              pinOut,
  output logic              pinOe,
  output logic [STAT_W-1:0] statusWord,
  output logic              irqOut
);
  logic             syncLvl;
  logic             prevLvl;
  logic             hitRise;
  logic             hitFall;
  logic             anyHit;
  logic [EVT_W-1:0] setVec;
  logic [EVT_W-1:0] evtFlags;

  pin_io_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .din (pinIn),
    .dout (syncLvl)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prevLvl <= 1'b0;
    else        prevLvl <= syncLvl;

  always_comb begin
    hitRise          = ctl.armRise && syncLvl && !prevLvl;
    hitFall          = ctl.armFall && !syncLvl && prevLvl;
    anyHit           = hitRise || hitFall;
    setVec           = '0;
    setVec[EVT_ANY]  = anyHit;
    setVec[EVT_RISE] = hitRise;
    setVec[EVT_FALL] = hitFall;
    setVec[EVT_OVR]  = anyHit && evtFlags[EVT_ANY] && !ctl.clearMask[EVT_ANY];
  end

  genvar b;
  generate
    for (b = 0; b < EVT_W; b++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) evtFlags[b] <= 1'b0;
        else        evtFlags[b] <= (evtFlags[b] && !ctl.clearMask[b]) || setVec[b];
    end
  endgenerate

  always_comb begin
    pinOe  = ctl.driveEn && !(ctl.openDrain && ctl.driveHigh);
    pinOut = pinOe && ctl.driveHigh;
    statusWord            = '0;
    statusWord[EVT_W-1:0] = evtFlags;
    statusWord[LEVEL_BIT] = syncLvl;
    irqOut = ctl.irqEnable && (|evtFlags);
  end
endmodule

// File: rtl/pin_io_top.sv
module pin_io_top
  import pin_io_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STAT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        modeFunc,
  input  logic [1:0]        modeGpio,
  input  logic              modeOpenDrain,
  input  logic              modeIrqEn,
  input  logic [1:0]        modeEdge,
  input  logic              statusWrEn,
  input  logic [EVT_W-1:0]  statusWrData,
  input  logic              pinIn,
  output logic              pinOut,
  output logic              pinOe,
  output logic [STAT_W-1:0] statusWord,
  output logic              irqOut
);
  pinCtl_t ctl;

  pin_io_ctrl u_ctrl (
    .modeFunc (modeFunc),
    .modeGpio (modeGpio),
    .modeOpenDrain (modeOpenDrain),
    .modeIrqEn (modeIrqEn),
    .modeEdge (modeEdge),
    .statusWrEn (statusWrEn),
    .statusWrData (statusWrData),
    .ctl (ctl)
  );

  pin_io_dp #(.SYNC_STAGES(SYNC_STAGES), .STAT_W(STAT_W)) u_dp (
    .clk (clk),
    .rst_n (rst_n),
    .pinIn (pinIn),
    .ctl (ctl),
    .pinOut (pinOut),
    .pinOe (pinOe),
    .statusWord (statusWord),
    .irqOut (irqOut)
  );
endmodule

// File: rtl/pin_io_checker.sv
module pin_io_checker
  import pin_io_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        modeFunc,
  input logic [1:0]        modeGpio,
  input logic              modeOpenDrain,
  input logic              modeIrqEn,
  input logic              statusWrEn,
  input logic [EVT_W-1:0]  statusWrData,
  input logic              pinIn,
  input logic              pinOe,
  input logic [STAT_W-1:0] statusWord,
  input logic              irqOut
);
  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              upCnt <= 2'd0;
    else if (upCnt != 2'd3)  upCnt <= upCnt + 2'd1;

  // R1: level bit follows the pin two edges later
  p_level_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt == 2'd3) |-> (statusWord[LEVEL_BIT] == $past(pinIn, 2)));

  // R3: open-drain high never drives
  p_od_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOpenDrain && modeGpio == 2'b11) |-> !pinOe);

  // R4: no new event outside capture mode
  p_no_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (modeFunc != FUNC_CAPTURE) |=> !$rose(statusWord[EVT_ANY]));

  // R7: an event flag stays until cleared
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (statusWord[EVT_ANY] && !(statusWrEn && statusWrData[EVT_ANY])) |=> statusWord[EVT_ANY]);

  // R9: interrupt only with enable and a pending flag
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (modeIrqEn && (|statusWord[EVT_W-1:0])));

  // R10: capture mode keeps the pin an input
  p_capture_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (modeFunc == FUNC_CAPTURE) |-> !pinOe);
endmodule

bind pin_io_top pin_io_checker #(.STAT_W(STAT_W)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .modeFunc (modeFunc),
  .modeGpio (modeGpio),
  .modeOpenDrain (modeOpenDrain),
  .modeIrqEn (modeIrqEn),
  .statusWrEn (statusWrEn),
  .statusWrData (statusWrData),
  .pinIn (pinIn),
  .pinOe (pinOe),
  .statusWord (statusWord),
  .irqOut (irqOut)
);

// File: tb/sim_pin_io_top.sv
module sim_pin_io_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  modeFunc = 3'd0;
  logic [1:0]  modeGpio = 2'd0;
  logic        modeOpenDrain = 1'b0;
  logic        modeIrqEn = 1'b0;
  logic [1:0]  modeEdge = 2'd0;
  logic        statusWrEn = 1'b0;
  logic [3:0]  statusWrData = 4'd0;
  logic        pinIn = 1'b0;
  logic        pinOut;
  logic        pinOe;
  logic [15:0] statusWord;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pin_io_top u0 (
    .clk (clk), .rst_n (rst_n),
    .modeFunc (modeFunc), .modeGpio (modeGpio),
    .modeOpenDrain (modeOpenDrain), .modeIrqEn (modeIrqEn),
    .modeEdge (modeEdge), .statusWrEn (statusWrEn),
    .statusWrData (statusWrData), .pinIn (pinIn),
    .pinOut (pinOut), .pinOe (pinOe),
    .statusWord (statusWord), .irqOut (irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic setMode(input logic [2:0] f, input logic [1:0] g, input logic od,
                         input logic ie, input logic [1:0] e);
    @(negedge clk);
    modeFunc = f; modeGpio = g; modeOpenDrain = od; modeIrqEn = ie; modeEdge = e;
    #1;
  endtask

  task automatic pinTo(input logic v);
    @(negedge clk);
    pinIn = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic w1c(input logic [3:0] m);
    @(negedge clk);
    statusWrEn = 1'b1; statusWrData = m;
    @(posedge clk);
    @(negedge clk);
    statusWrEn = 1'b0; statusWrData = 4'd0;
  endtask

  task automatic t_reset;
    chk("R6 reset flags", {16'd0, statusWord}, 32'd0);
    chk("R9 reset irq", {31'd0, irqOut}, 32'd0);
    chk("R2 reset oe", {31'd0, pinOe}, 32'd0);
  endtask

  task automatic t_sync;
    setMode(3'd4, 2'b00, 1'b0, 1'b0, 2'b11);
    @(negedge clk); pinIn = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 level after one edge", {31'd0, statusWord[8]}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R1 level after two edges", {31'd0, statusWord[8]}, 32'd1);
    pinTo(1'b0);
    chk("R1 level low again", {31'd0, statusWord[8]}, 32'd0);
    chk("R4 no flags outside capture", {28'd0, statusWord[3:0]}, 32'd0);
  endtask

  task automatic t_gpio;
    setMode(3'd4, 2'b00, 1'b0, 1'b0, 2'b00);
    chk("R2 code 00 input", {31'd0, pinOe}, 32'd0);
    setMode(3'd4, 2'b01, 1'b0, 1'b0, 2'b00);
    chk("R2 code 01 input", {31'd0, pinOe}, 32'd0);
    setMode(3'd4, 2'b10, 1'b0, 1'b0, 2'b00);
    chk("R2 code 10 drive low", {30'd0, pinOe, pinOut}, 32'b10);
    setMode(3'd4, 2'b11, 1'b0, 1'b0, 2'b00);
    chk("R2 code 11 drive high", {30'd0, pinOe, pinOut}, 32'b11);
  endtask

  task automatic t_open_drain;
    setMode(3'd4, 2'b11, 1'b1, 1'b0, 2'b00);
    chk("R3 open-drain high released", {31'd0, pinOe}, 32'd0);
    setMode(3'd4, 2'b10, 1'b1, 1'b0, 2'b00);
    chk("R3 open-drain low driven", {30'd0, pinOe, pinOut}, 32'b10);
  endtask

  task automatic t_capture_input;
    setMode(3'd1, 2'b11, 1'b0, 1'b0, 2'b00);
    chk("R10 capture ignores output high", {31'd0, pinOe}, 32'd0);
    setMode(3'd1, 2'b10, 1'b0, 1'b0, 2'b00);
    chk("R10 capture ignores output low", {31'd0, pinOe}, 32'd0);
  endtask

  task automatic t_rise;
    setMode(3'd1, 2'b00, 1'b0, 1'b0, 2'b01);
    pinTo(1'b1);
    chk("R6 rising flags", {28'd0, statusWord[3:0]}, 32'h3);
    w1c(4'hF);
    pinTo(1'b0);
    chk("R5 falling ignored in rise mode", {28'd0, statusWord[3:0]}, 32'h0);
  endtask

  task automatic t_fall;
    setMode(3'd1, 2'b00, 1'b0, 1'b0, 2'b10);
    pinTo(1'b1);
    chk("R5 rising ignored in fall mode", {28'd0, statusWord[3:0]}, 32'h0);
    pinTo(1'b0);
    chk("R6 falling flags", {28'd0, statusWord[3:0]}, 32'h5);
    w1c(4'hF);
  endtask

  task automatic t_both_overrun;
    setMode(3'd1, 2'b00, 1'b0, 1'b0, 2'b11);
    pinTo(1'b1);
    chk("R5 both mode rising", {28'd0, statusWord[3:0]}, 32'h3);
    pinTo(1'b0);
    chk("R6 overrun on second edge", {28'd0, statusWord[3:0]}, 32'hF);
  endtask

  task automatic t_w1c_irq;
    w1c(4'h5);
    chk("R7 partial clear", {28'd0, statusWord[3:0]}, 32'hA);
    w1c(4'h0);
    chk("R7 zero write keeps flags", {28'd0, statusWord[3:0]}, 32'hA);
    chk("R9 irq masked", {31'd0, irqOut}, 32'd0);
    setMode(3'd1, 2'b00, 1'b0, 1'b1, 2'b11);
    chk("R9 irq enabled", {31'd0, irqOut}, 32'd1);
    w1c(4'hF);
    chk("R9 irq drops after clear", {31'd0, irqOut}, 32'd0);
  endtask

  task automatic t_none_and_off;
    setMode(3'd1, 2'b00, 1'b0, 1'b0, 2'b00);
    pinTo(1'b1);
    pinTo(1'b0);
    chk("R5 no edge selected", {28'd0, statusWord[3:0]}, 32'h0);
    setMode(3'd4, 2'b00, 1'b0, 1'b0, 2'b11);
    pinTo(1'b1);
    pinTo(1'b0);
    chk("R4 gpio function no events", {28'd0, statusWord[3:0]}, 32'h0);
  endtask

  task automatic t_set_beats_clear;
    setMode(3'd1, 2'b00, 1'b0, 1'b0, 2'b01);
    pinTo(1'b1);
    pinTo(1'b0);
    chk("R8 setup flags", {28'd0, statusWord[3:0]}, 32'h3);
    @(negedge clk); pinIn = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); statusWrEn = 1'b1; statusWrData = 4'h3;
    @(posedge clk);
    @(negedge clk); statusWrEn = 1'b0; statusWrData = 4'h0;
    chk("R8 edge wins over clear", {28'd0, statusWord[3:0]}, 32'h3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_sync();
    t_gpio();
    t_open_drain();
    t_capture_input();
    t_rise();
    t_fall();
    t_both_overrun();
    t_w1c_irq();
    t_none_and_off();
    t_set_beats_clear();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule